// File: doc/BRIEF.md
# Serial Programming Command Receiver

This block sits on the target side of a two-wire programming port: one clock line driven by an external programmer and one data line. In this block the data line is only ever an input. The block samples both lines in its own system clock domain and collects 20 bits on consecutive falling edges of the port clock. Each group is a 4-bit command followed by a 16-bit payload, and it is then decoded.

Depending on the command, the payload is handed to the processor core as an instruction word or presented on a write port to the write buffer. A write can use the current table pointer unchanged, advance the pointer by two after the write, or start a programming cycle. When a programming cycle starts, the block runs a programming-hold interval and then a discharge interval. Port clock edges are ignored during both intervals. The core can overwrite the 22-bit table pointer directly.

Top module: `spcr_top`

## Requirements
- R1: While reset is asserted and after it is released, instr_valid, wr_en, prog_start, prog_hold and discharge are 0 and tbl_ptr is 0.
- R2: A frame is 20 falling edges of sclk_i. The bit sampled on each falling edge comes in LSB first. The first 4 bits form the command, with bit 0 first. The next 16 bits form the payload, with payload bit 0 first, so the payload's low byte arrives before its high byte.
- R3: Command 4'b0000 gives exactly one instr_valid pulse with instr_word equal to the payload. No write occurs and tbl_ptr is unchanged.
- R4: Command 4'b1100 gives exactly one wr_en pulse with wr_addr equal to tbl_ptr and wr_data equal to the payload. tbl_ptr is unchanged.
- R5: Command 4'b1101 writes the same way as R4 and then sets tbl_ptr to the old value plus 2, modulo 2^22.
- R6: Command 4'b1111 writes the same way as R4 and pulses prog_start in the same cycle as wr_en. It leaves tbl_ptr unchanged.
- R7: After prog_start, prog_hold is high for exactly PROG_CYCLES cycles. discharge is then high for exactly DISCH_CYCLES cycles. The two signals are never high together.
- R8: Falling edges of sclk_i that occur during the programming-hold or discharge interval are not counted. The next frame after the interval is decoded from its own 20 bits.
- R9: Any command code other than 0000, 1100, 1101 and 1111 produces no pulse on any output and leaves tbl_ptr unchanged. The frame that follows is still aligned.
- R10: A cycle with core_ptr_ld high loads core_ptr_val into tbl_ptr on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Programming port clock line |
| sdata_i | input | 1 | Programming port data line (input only) |
| core_ptr_ld | input | 1 | Core request to load the table pointer |
| core_ptr_val | input | 22 | Value loaded into the table pointer |
| instr_valid | output | 1 | One-cycle pulse: instr_word holds a core instruction |
| instr_word | output | 16 | Instruction word for the core |
| wr_en | output | 1 | One-cycle write strobe to the write buffer |
| wr_addr | output | 22 | Table pointer value used for the write |
| wr_data | output | 16 | Two payload bytes, low byte in bits 7:0 |
| tbl_ptr | output | 22 | Current table pointer |
| prog_start | output | 1 | One-cycle pulse: a programming cycle starts |
| prog_hold | output | 1 | Programming-hold interval in progress |
| discharge | output | 1 | Discharge interval in progress |

## Verification
The bench sends every one of the 16 command codes with a distinct payload and a distinct preloaded pointer. This catches a decoder that confuses the 1100 and 1101 codes, that acts on an unknown code, or that takes the bits in the wrong order, any of which would put the wrong data or the wrong address on the write port. A pointer preloaded to 3FFFFEh shows whether the post-increment wraps to zero or carries into bits that do not exist. Port clock pulses sent during the programming-hold interval show whether the framer counts bits while it should be ignoring them; a framer that did would decode the next instruction shifted by several bits. The lengths of the hold and discharge intervals are counted cycle by cycle, which exposes an off-by-one in the interval timer.

// File: rtl/spcr_pkg.sv
package spcr_pkg;
  localparam int CMD_W   = 4;
  localparam int PAY_W   = 16;
  localparam int FRAME_W = CMD_W + PAY_W;
  localparam int PTR_W   = 22;
  localparam int PTR_STEP = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_CORE    = 4'b0000,
    CMD_WR      = 4'b1100,
    CMD_WR_INC  = 4'b1101,
    CMD_WR_PROG = 4'b1111
  } cmd_e;

  typedef enum logic [1:0] {
    HT_IDLE  = 2'd0,
    HT_PROG  = 2'd1,
    HT_DISCH = 2'd2
  } hold_st_e;
endpackage

// File: rtl/spcr_edge.sv
module spcr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic fall_o,
  output logic bit_o
);
  logic [STAGES-1:0] clk_sync_q, clk_sync_d;
  logic [STAGES-1:0] dat_sync_q, dat_sync_d;
  logic              clk_prev_q;

  always_comb begin
    clk_sync_d = {clk_sync_q[STAGES-2:0], sclk_i};
    dat_sync_d = {dat_sync_q[STAGES-2:0], sdata_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync_q <= '0;
      dat_sync_q <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      clk_sync_q <= clk_sync_d;
      dat_sync_q <= dat_sync_d;
      clk_prev_q <= clk_sync_q[STAGES-1];
    end
  end

  assign fall_o = clk_prev_q & ~clk_sync_q[STAGES-1];
  assign bit_o  = dat_sync_q[STAGES-1];
endmodule

// File: rtl/spcr_framer.sv
module spcr_framer
  import spcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic             bit_i,
  input  logic             busy_i,
  output logic             frame_done_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [PAY_W-1:0] payload_o
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               done_q, done_d;
  logic               take;

  assign take = fall_i & ~busy_i;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (busy_i) begin
      cnt_d = '0;
    end else if (take) begin
      shreg_d = {bit_i, shreg_q[FRAME_W-1:1]};
      if (cnt_q == CNT_W'(FRAME_W - 1)) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign frame_done_o = done_q;
  assign cmd_o        = shreg_q[CMD_W-1:0];
  assign payload_o    = shreg_q[FRAME_W-1:CMD_W];
endmodule

// File: rtl/spcr_decode.sv
module spcr_decode
  import spcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic             core_ptr_ld,
  input  logic [PTR_W-1:0] core_ptr_val,
  output logic             instr_valid,
  output logic [PAY_W-1:0] instr_word,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PAY_W-1:0] wr_data,
  output logic [PTR_W-1:0] tbl_ptr,
  output logic             prog_start
);
  logic             iv_q, iv_d, we_q, we_d, ps_q, ps_d;
  logic [PAY_W-1:0] iw_q, iw_d, wd_q, wd_d;
  logic [PTR_W-1:0] wa_q, wa_d, ptr_q, ptr_d;
  logic             is_wr, is_inc;

  always_comb begin
    is_wr  = 1'b0;
    is_inc = 1'b0;
    iv_d   = 1'b0;
    ps_d   = 1'b0;
    if (frame_done_i) begin
      case (cmd_e'(cmd_i))
        CMD_CORE:    iv_d = 1'b1;
        CMD_WR:      is_wr = 1'b1;
        CMD_WR_INC:  begin is_wr = 1'b1; is_inc = 1'b1; end
        CMD_WR_PROG: begin is_wr = 1'b1; ps_d = 1'b1; end
        default:     ;
      endcase
    end
    we_d = is_wr;
    iw_d = iv_d  ? payload_i : iw_q;
    wd_d = is_wr ? payload_i : wd_q;
    wa_d = is_wr ? ptr_q     : wa_q;
    if (core_ptr_ld)  ptr_d = core_ptr_val;
    else if (is_inc)  ptr_d = ptr_q + PTR_W'(PTR_STEP);
    else              ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q  <= 1'b0;
      we_q  <= 1'b0;
      ps_q  <= 1'b0;
      iw_q  <= '0;
      wd_q  <= '0;
      wa_q  <= '0;
      ptr_q <= '0;
    end else begin
      iv_q  <= iv_d;
      we_q  <= we_d;
      ps_q  <= ps_d;
      iw_q  <= iw_d;
      wd_q  <= wd_d;
      wa_q  <= wa_d;
      ptr_q <= ptr_d;
    end
  end

  assign instr_valid = iv_q;
  assign instr_word  = iw_q;
  assign wr_en       = we_q;
  assign wr_addr     = wa_q;
  assign wr_data     = wd_q;
  assign tbl_ptr     = ptr_q;
  assign prog_start  = ps_q;
endmodule

// File: rtl/spcr_hold.sv
module spcr_hold
  import spcr_pkg::*;
#(
  parameter int PROG_CYCLES  = 40,
  parameter int DISCH_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic prog_hold,
  output logic discharge
);
  localparam int MAXC  = (PROG_CYCLES > DISCH_CYCLES) ? PROG_CYCLES : DISCH_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  hold_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      HT_IDLE: if (start_i) begin
        st_d  = HT_PROG;
        cnt_d = CNT_W'(PROG_CYCLES - 1);
      end
      HT_PROG: if (cnt_q == '0) begin
        st_d  = HT_DISCH;
        cnt_d = CNT_W'(DISCH_CYCLES - 1);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      HT_DISCH: if (cnt_q == '0) begin
        st_d = HT_IDLE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      default: st_d = HT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HT_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign prog_hold = (st_q == HT_PROG);
  assign discharge = (st_q == HT_DISCH);
endmodule

// File: rtl/spcr_top.sv
module spcr_top
  import spcr_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PROG_CYCLES  = 40,
  parameter int DISCH_CYCLES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             core_ptr_ld,
  input  logic [PTR_W-1:0] core_ptr_val,
  output logic             instr_valid,
  output logic [PAY_W-1:0] instr_word,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PAY_W-1:0] wr_data,
  output logic [PTR_W-1:0] tbl_ptr,
  output logic             prog_start,
  output logic             prog_hold,
  output logic             discharge
);
  logic             fall, sbit, busy, frame_done;
  logic [CMD_W-1:0] frm_cmd;
  logic [PAY_W-1:0] frm_pay;

  assign busy = prog_start | prog_hold | discharge;

  spcr_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .fall_o(fall), .bit_o(sbit)
  );

  spcr_framer u_framer (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .bit_i(sbit), .busy_i(busy),
    .frame_done_o(frame_done), .cmd_o(frm_cmd), .payload_o(frm_pay)
  );

  spcr_decode u_decode (
    .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done), .cmd_i(frm_cmd),
    .payload_i(frm_pay), .core_ptr_ld(core_ptr_ld), .core_ptr_val(core_ptr_val),
    .instr_valid(instr_valid), .instr_word(instr_word), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tbl_ptr(tbl_ptr),
    .prog_start(prog_start)
  );

  spcr_hold #(.PROG_CYCLES(PROG_CYCLES), .DISCH_CYCLES(DISCH_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .start_i(prog_start),
    .prog_hold(prog_hold), .discharge(discharge)
  );
endmodule

// File: rtl/spcr_checker.sv
module spcr_checker
  import spcr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             core_ptr_ld,
  input logic             frame_done,
  input logic [CMD_W-1:0] frm_cmd,
  input logic             instr_valid,
  input logic             wr_en,
  input logic [PTR_W-1:0] tbl_ptr,
  input logic             prog_start,
  input logic             prog_hold,
  input logic             discharge
);
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_valid, wr_en})); // R3
  AST_PTR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_ptr_ld && !frame_done) |=> $stable(tbl_ptr)); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !core_ptr_ld && frm_cmd == 4'b1101) |=> tbl_ptr == PTR_W'($past(tbl_ptr) + PTR_W'(2))); // R5
  AST_START_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wr_en); // R6
  AST_START_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> prog_hold); // R7
  AST_PHASES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_hold, discharge})); // R7
  AST_DISCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_hold) |-> discharge); // R7
  AST_NO_FRAME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_hold || discharge) |-> !frame_done); // R8
endmodule

bind spcr_top spcr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .core_ptr_ld(core_ptr_ld), .frame_done(frame_done),
  .frm_cmd(frm_cmd), .instr_valid(instr_valid), .wr_en(wr_en), .tbl_ptr(tbl_ptr),
  .prog_start(prog_start), .prog_hold(prog_hold), .discharge(discharge)
);

// File: tb/spcr_top_tb.sv
module spcr_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;
  localparam int PROG_C     = 40;
  localparam int DISCH_C    = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk_i, sdata_i, core_ptr_ld;
  logic [21:0] core_ptr_val;
  logic        instr_valid, wr_en, prog_start, prog_hold, discharge;
  logic [15:0] instr_word, wr_data;
  logic [21:0] wr_addr, tbl_ptr;

  int checks = 0, errors = 0;
  int n_iv, n_we, n_ps, n_hold, n_disch;
  logic [15:0] last_iw, last_wd;
  logic [21:0] last_wa;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spcr_top u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .core_ptr_ld(core_ptr_ld), .core_ptr_val(core_ptr_val),
    .instr_valid(instr_valid), .instr_word(instr_word), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tbl_ptr(tbl_ptr),
    .prog_start(prog_start), .prog_hold(prog_hold), .discharge(discharge)
  );

  always @(negedge clk) begin
    if (instr_valid) begin n_iv++; last_iw = instr_word; end
    if (wr_en) begin n_we++; last_wd = wr_data; last_wa = wr_addr; end
    if (prog_start) n_ps++;
    if (prog_hold) n_hold++;
    if (discharge) n_disch++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_iv = 0; n_we = 0; n_ps = 0; n_hold = 0; n_disch = 0;
  endtask

  task automatic send_bit(input logic b);
    sclk_i = 1'b1; sdata_i = b;
    repeat (HALF_SCLK) @(negedge clk);
    sclk_i = 1'b0;
    repeat (HALF_SCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [3:0] cmd, input logic [15:0] pay);
    logic [19:0] bits;
    bits = {pay, cmd};
    for (int i = 0; i < 20; i++) send_bit(bits[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic load_ptr(input logic [21:0] v);
    core_ptr_ld = 1'b1; core_ptr_val = v;
    @(negedge clk);
    core_ptr_ld = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sclk_i = 1'b0; sdata_i = 1'b0;
    core_ptr_ld = 1'b0; core_ptr_val = '0;
    clear_log();
    repeat (3) @(negedge clk);
    chk(!instr_valid && !wr_en && !prog_start && !prog_hold && !discharge && tbl_ptr == 0,
        "R1 reset outputs", {prog_hold, discharge, prog_start, wr_en, instr_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tbl_ptr == 0 && n_iv == 0 && n_we == 0, "R1 after release", tbl_ptr, 0);

    // R10 pointer load through the core side
    load_ptr(22'h2A5F3C);
    chk(tbl_ptr == 22'h2A5F3C, "R10 core load", tbl_ptr, 22'h2A5F3C);

    // Sweep of all command codes (R2 R3 R4 R5 R6 R7 R9)
    for (int c = 0; c < 16; c++) begin
      logic [21:0] base;
      logic [15:0] pay;
      base = 22'h010000 + 22'(c * 36);
      pay  = 16'(16'h3C81 ^ (c * 16'h1357));
      load_ptr(base);
      clear_log();
      send_frame(4'(c), pay);
      if (c == 4'hF) repeat (PROG_C + DISCH_C + 8) @(negedge clk);
      case (c)
        0: begin
          chk(n_iv == 1 && last_iw == pay, "R3 core instruction", last_iw, pay);
          chk(n_we == 0 && tbl_ptr == base, "R3 no write", n_we, 0);
        end
        12: begin
          chk(n_we == 1 && last_wd == pay && last_wa == base, "R4 write data", last_wd, pay);
          chk(tbl_ptr == base && n_iv == 0, "R4 pointer kept", tbl_ptr, base);
        end
        13: begin
          chk(n_we == 1 && last_wd == pay && last_wa == base, "R5 write data", last_wa, base);
          chk(tbl_ptr == base + 22'd2, "R5 pointer plus 2", tbl_ptr, base + 22'd2);
        end
        15: begin
          chk(n_we == 1 && n_ps == 1 && last_wd == pay && last_wa == base, "R6 write and start", n_ps, 1);
          chk(tbl_ptr == base, "R6 pointer kept", tbl_ptr, base);
          chk(n_hold == PROG_C, "R7 hold length", n_hold, PROG_C);
          chk(n_disch == DISCH_C, "R7 discharge length", n_disch, DISCH_C);
        end
        default: begin
          chk(n_iv == 0 && n_we == 0 && n_ps == 0, "R9 unknown code silent", c, 0);
          chk(tbl_ptr == base, "R9 pointer kept", tbl_ptr, base);
        end
      endcase
    end

    // R9 alignment after an unknown code
    clear_log();
    send_frame(4'b0110, 16'hFFFF);
    send_frame(4'b0000, 16'h8001);
    chk(n_iv == 1 && last_iw == 16'h8001, "R9 alignment kept", last_iw, 16'h8001);

    // R2 byte order: low byte in wr_data[7:0]
    load_ptr(22'h000100);
    clear_log();
    send_frame(4'b1100, {8'hB7, 8'h4E});
    chk(last_wd[7:0] == 8'h4E && last_wd[15:8] == 8'hB7, "R2 byte order", last_wd, 16'hB74E);

    // R5 wrap at top of pointer space
    load_ptr(22'h3FFFFE);
    clear_log();
    send_frame(4'b1101, 16'h0F0F);
    chk(last_wa == 22'h3FFFFE, "R5 wrap write addr", last_wa, 22'h3FFFFE);
    chk(tbl_ptr == 22'h000000, "R5 wrap pointer", tbl_ptr, 0);

    // R8 edges during the hold interval are not counted
    clear_log();
    send_frame(4'b1111, 16'h1234);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    repeat (PROG_C + DISCH_C) @(negedge clk);
    chk(!prog_hold && !discharge, "R8 interval over", {prog_hold, discharge}, 0);
    send_frame(4'b0000, 16'h5AC3);
    chk(n_iv == 1 && last_iw == 16'h5AC3, "R8 frame after hold", last_iw, 16'h5AC3);

    // Consecutive incrementing writes
    load_ptr(22'h001000);
    for (int k = 0; k < 4; k++) begin
      clear_log();
      send_frame(4'b1101, 16'(k * 16'h1111));
      chk(last_wa == 22'h001000 + 22'(2 * k), "R5 sequence addr", last_wa, 22'h001000 + 22'(2 * k));
    end
    chk(tbl_ptr == 22'h001008, "R5 sequence end", tbl_ptr, 22'h001008);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule